// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block steps one display pipe through the power-saving self-refresh states. Software writes a control word on a single-cycle strobe. The word holds an enable bit, an active-entry bit, a single-frame-update request, an automatic-entry mode bit, an idle-frame threshold and a wake-up training-time code. The sequencer follows frame boundaries through a vsync pulse. It reports its state as a 3-bit code, flags the states that last one frame, tells the link layer when frame transmission is halted, and pulses a request for the sink wake-up message on the way out of self-refresh.

In manual use, software enables the block, sets active-entry to start the static-frame entry, and clears active-entry to leave. Software may also request one refreshed frame before a flip while self-refresh is held. In automatic mode, the block starts entry on its own after a run of quiet frames, one longer than the programmed threshold. Requests that make no sense in the present state are dropped, and a sticky error bit records them.

Top module: `psr_seq`

## Requirements
- R1: After reset the state code is 0 (off), in_trans and link_idle are 0, and wake_req and err are 0.
- R2: A write with enable=1 from state 0 moves the state to 1 (idle) on the clock after the write. Without active-entry or automatic mode, the state stays 1 across any number of cycles and vsyncs.
- R3: With enable and active-entry stored, state 1 moves to 2 (entering) on the next clock. State 2 holds until a vsync, and the clock edge that samples vsync moves it to 3 (held).
- R4: Clearing active-entry while in state 3 moves the state to 5 (leaving) on the next clock, never through 4. wake_req is high for exactly the first cycle in state 5. The vsync edge in state 5 returns the state to 1.
- R5: A single-frame-update request written while in state 3 reads back as 1 and moves the state to 4 on the next clock. State 4 lasts until a vsync, which returns the state to 3. The request bit reads 0 from that point on.
- R6: in_trans is 1 exactly in states 2, 4 and 5. link_idle is 1 exactly in state 3.
- R7: A write with enable=0 outside states 2, 4 and 5 clears the stored active-entry, mode and single-frame-update bits together. The state is 0 on the following clock.
- R8: In automatic mode with threshold N, counting takes place in state 1. The (N+1)-th consecutive vsync with no frame update moves the state to 2 at that edge, and the active-entry readback becomes 1.
- R9: A vsync with frame_dirty high resets the idle-frame count, so a further N+1 clean vsyncs are needed before automatic entry.
- R10: wake_sel encodes the stored training-time code c as 3 (2500 us) when c>5, 2 (500 us) when c>1, 1 (100 us) when c>0, and 0 (0 us) otherwise.
- R11: Three write requests are illegal: active-entry=1 while enable is stored low, single-frame-update=1 outside state 3, and enable=0 while in state 2, 4 or 5. An illegal write is dropped whole and sets err, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control-word write strobe |
| wr_enable | input | 1 | Enable field of the written word |
| wr_entry | input | 1 | Active-entry field |
| wr_sfu | input | 1 | Single-frame-update request field (set-only) |
| wr_auto | input | 1 | Automatic-entry mode field |
| wr_idle | input | IDLE_W | Idle-frame threshold N |
| wr_wake | input | WCODE_W | Wake-up training-time code |
| vsync | input | 1 | One-cycle frame-boundary pulse |
| frame_dirty | input | 1 | Frame update flagged, sampled with vsync |
| state_o | output | 3 | Current state code 0..5 |
| in_trans | output | 1 | High in the one-frame states 2, 4, 5 |
| link_idle | output | 1 | Frame transmission halted (state 3) |
| wake_req | output | 1 | One-cycle request to send the sink wake-up message |
| wake_sel | output | 2 | Selected training time, 0..3 = 0/100/500/2500 us |
| entry_rb | output | 1 | Stored active-entry bit |
| sfu_rb | output | 1 | Stored single-frame-update request |
| err | output | 1 | Sticky illegal-request flag |

## Verification
The bench sweeps every idle threshold a 4-bit field can hold and every training-time code. It checks the cycle just before automatic entry and the cycle of entry. A counter off by one, or one missing the added frame, would enter one frame early or one frame late. A dirty vsync inserted just before the entry point would still let the block enter if the count reset were missing. On exit the bench checks for state 5 one clock after active-entry clears. A design that passed through state 4, repeated the wake pulse or left the self-clearing request set would show the wrong state or readback there. Each illegal request is tried in isolation after a reset. A design that accepted any of them would show a changed state or readback, or would leave err low.

// File: rtl/psr_seq_pkg.sv
package psr_seq_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_IDLE     = 3'd1,
        PS_ENTER    = 3'd2,
        PS_HOLD     = 3'd3,
        PS_ONEFRAME = 3'd4,
        PS_LEAVE    = 3'd5
    } psr_state_e;

    typedef enum logic [1:0] {
        WK_0US    = 2'd0,
        WK_100US  = 2'd1,
        WK_500US  = 2'd2,
        WK_2500US = 2'd3
    } wake_sel_e;

    typedef struct packed {
        logic enable;
        logic entry;
        logic sfu;
        logic autoen;
    } psr_ctl_t;

    function automatic wake_sel_e wake_map(input int unsigned code);
        if (code > 5)      return WK_2500US;
        else if (code > 1) return WK_500US;
        else if (code > 0) return WK_100US;
        else               return WK_0US;
    endfunction

    function automatic logic is_transit(input psr_state_e s);
        return (s == PS_ENTER) || (s == PS_ONEFRAME) || (s == PS_LEAVE);
    endfunction

endpackage

// File: rtl/psr_ctl_regs.sv
module psr_ctl_regs
    import psr_seq_pkg::*;
#(
    parameter int IDLE_W  = 4,
    parameter int WCODE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  psr_ctl_t           wr_ctl,
    input  logic [IDLE_W-1:0]  wr_idle,
    input  logic [WCODE_W-1:0] wr_wake,
    input  psr_state_e         state,
    input  logic               auto_fire,
    input  logic               sfu_done,
    output psr_ctl_t           ctl_q,
    output logic [IDLE_W-1:0]  idle_q,
    output logic [WCODE_W-1:0] wake_q,
    output logic               err_q
);

    logic bad_entry, bad_sfu, bad_off, illegal;

    always_comb begin
        bad_entry = wr_ctl.entry && !ctl_q.enable;
        bad_sfu   = wr_ctl.sfu && (state != PS_HOLD);
        bad_off   = !wr_ctl.enable && ctl_q.enable && is_transit(state);
        illegal   = wr_en && (bad_entry || bad_sfu || bad_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            idle_q <= '0;
            wake_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_en && !illegal) begin
                if (!wr_ctl.enable) begin
                    ctl_q <= '0;
                end else begin
                    ctl_q.enable <= 1'b1;
                    ctl_q.entry  <= wr_ctl.entry;
                    ctl_q.autoen <= wr_ctl.autoen;
                    ctl_q.sfu    <= (ctl_q.sfu && !sfu_done) || wr_ctl.sfu;
                end
                idle_q <= wr_idle;
                wake_q <= wr_wake;
            end else begin
                if (auto_fire) ctl_q.entry <= 1'b1;
                if (sfu_done)  ctl_q.sfu   <= 1'b0;
            end
            if (illegal) err_q <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R11

    AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctl.entry && !ctl_q.enable) |=> !ctl_q.entry); // R11

    AST_SFU_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sfu_done |=> !ctl_q.sfu); // R5

endmodule

// File: rtl/psr_idle_cnt.sv
module psr_idle_cnt #(
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  logic              vsync,
    input  logic              dirty,
    input  logic [IDLE_W-1:0] limit,
    output logic              fire
);

    localparam int CW = IDLE_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] target;

    always_comb begin
        target = {1'b0, limit} + CW'(1);
        fire   = count_en && vsync && !dirty && ((cnt + CW'(1)) == target);
    end

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt <= '0;
        end else if (vsync) begin
            if (dirty || fire) cnt <= '0;
            else               cnt <= cnt + CW'(1);
        end
    end

    AST_DIRTY_RESETS: assert property (@(posedge clk) disable iff (rst)
        (count_en && vsync && dirty) |=> (cnt == '0)); // R9

    AST_FIRE_RESETS: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cnt == '0)); // R8

endmodule

// File: rtl/psr_fsm.sv
module psr_fsm
    import psr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  psr_ctl_t   ctl,
    input  logic       vsync,
    input  logic       auto_fire,
    output psr_state_e state,
    output logic       wake_req
);

    psr_state_e nxt;

    always_comb begin
        nxt = state;
        if (!ctl.enable) begin
            nxt = PS_OFF;
        end else begin
            unique case (state)
                PS_OFF:      nxt = PS_IDLE;
                PS_IDLE:     if (ctl.entry || auto_fire) nxt = PS_ENTER;
                PS_ENTER:    if (vsync) nxt = PS_HOLD;
                PS_HOLD: begin
                    if (!ctl.entry)   nxt = PS_LEAVE;
                    else if (ctl.sfu) nxt = PS_ONEFRAME;
                end
                PS_ONEFRAME: if (vsync) nxt = PS_HOLD;
                PS_LEAVE:    if (vsync) nxt = PS_IDLE;
                default:     nxt = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_OFF;
            wake_req <= 1'b0;
        end else begin
            state    <= nxt;
            wake_req <= (nxt == PS_LEAVE) && (state != PS_LEAVE);
        end
    end

    AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == PS_OFF && ctl.enable) |=> (state == PS_IDLE)); // R2

    AST_ENTER_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ENTER && ctl.enable && !vsync) |=> (state == PS_ENTER)); // R3

    AST_ENTER_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ENTER && ctl.enable && vsync) |=> (state == PS_HOLD)); // R3

    AST_SKIP_ONEFRAME: assert property (@(posedge clk) disable iff (rst)
        (state == PS_HOLD && ctl.enable && !ctl.entry) |=> (state == PS_LEAVE)); // R4

    AST_LEAVE_RETURN: assert property (@(posedge clk) disable iff (rst)
        (state == PS_LEAVE && ctl.enable && vsync) |=> (state == PS_IDLE)); // R4

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req); // R4

    AST_NO_OFF_IN_TRANSIT: assert property (@(posedge clk) disable iff (rst)
        is_transit(state) |=> (state != PS_OFF)); // R7

endmodule

// File: rtl/psr_seq.sv
module psr_seq
    import psr_seq_pkg::*;
#(
    parameter int IDLE_W  = 4,
    parameter int WCODE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_enable,
    input  logic               wr_entry,
    input  logic               wr_sfu,
    input  logic               wr_auto,
    input  logic [IDLE_W-1:0]  wr_idle,
    input  logic [WCODE_W-1:0] wr_wake,
    input  logic               vsync,
    input  logic               frame_dirty,
    output logic [2:0]         state_o,
    output logic               in_trans,
    output logic               link_idle,
    output logic               wake_req,
    output logic [1:0]         wake_sel,
    output logic               entry_rb,
    output logic               sfu_rb,
    output logic               err
);

    psr_ctl_t           wr_ctl, ctl_q;
    logic [IDLE_W-1:0]  idle_q;
    logic [WCODE_W-1:0] wake_q;
    psr_state_e         state;
    logic               auto_fire, sfu_done, count_en;

    always_comb begin
        wr_ctl.enable = wr_enable;
        wr_ctl.entry  = wr_entry;
        wr_ctl.sfu    = wr_sfu;
        wr_ctl.autoen = wr_auto;
        count_en = (state == PS_IDLE) && ctl_q.enable && ctl_q.autoen && !ctl_q.entry;
        sfu_done = (state == PS_ONEFRAME) && vsync && ctl_q.enable;
    end

    psr_ctl_regs #(.IDLE_W(IDLE_W), .WCODE_W(WCODE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctl(wr_ctl),
        .wr_idle(wr_idle), .wr_wake(wr_wake), .state(state),
        .auto_fire(auto_fire), .sfu_done(sfu_done),
        .ctl_q(ctl_q), .idle_q(idle_q), .wake_q(wake_q), .err_q(err)
    );

    psr_idle_cnt #(.IDLE_W(IDLE_W)) u_cnt (
        .clk(clk), .rst(rst), .count_en(count_en), .vsync(vsync),
        .dirty(frame_dirty), .limit(idle_q), .fire(auto_fire)
    );

    psr_fsm u_fsm (
        .clk(clk), .rst(rst), .ctl(ctl_q), .vsync(vsync),
        .auto_fire(auto_fire), .state(state), .wake_req(wake_req)
    );

    always_comb begin
        state_o   = state;
        in_trans  = is_transit(state);
        link_idle = (state == PS_HOLD);
        wake_sel  = wake_map(32'(wake_q));
        entry_rb  = ctl_q.entry;
        sfu_rb    = ctl_q.sfu;
    end

    AST_SFU_ONLY_HELD: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ONEFRAME) |-> $past(state == PS_HOLD || state == PS_ONEFRAME)); // R5

endmodule

// File: tb/tb_psr_seq.sv
module tb_psr_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_enable = 1'b0, wr_entry = 1'b0, wr_sfu = 1'b0, wr_auto = 1'b0;
    logic [3:0] wr_idle = '0, wr_wake = '0;
    logic       vsync = 1'b0, frame_dirty = 1'b0;
    logic [2:0] state_o;
    logic       in_trans, link_idle, wake_req, entry_rb, sfu_rb, err;
    logic [1:0] wake_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psr_seq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_enable(wr_enable),
        .wr_entry(wr_entry), .wr_sfu(wr_sfu), .wr_auto(wr_auto),
        .wr_idle(wr_idle), .wr_wake(wr_wake), .vsync(vsync),
        .frame_dirty(frame_dirty), .state_o(state_o), .in_trans(in_trans),
        .link_idle(link_idle), .wake_req(wake_req), .wake_sel(wake_sel),
        .entry_rb(entry_rb), .sfu_rb(sfu_rb), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_st(input string tag, input int s);
        chk(tag, int'(state_o), s);
        chk("R6 in_trans", int'(in_trans), (s == 2 || s == 4 || s == 5) ? 1 : 0);
        chk("R6 link_idle", int'(link_idle), (s == 3) ? 1 : 0);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input bit en, input bit ent, input bit sf, input bit au,
                      input int idle, input int wake);
        @(negedge clk);
        wr_en = 1'b1; wr_enable = en; wr_entry = ent; wr_sfu = sf; wr_auto = au;
        wr_idle = 4'(idle); wr_wake = 4'(wake);
        @(negedge clk);
        wr_en = 1'b0; wr_enable = 1'b0; wr_entry = 1'b0; wr_sfu = 1'b0; wr_auto = 1'b0;
    endtask

    task automatic vs(input bit d);
        @(negedge clk);
        vsync = 1'b1; frame_dirty = d;
        @(negedge clk);
        vsync = 1'b0; frame_dirty = 1'b0;
    endtask

    function automatic int exp_wake(input int c);
        if (c > 5) return 3;
        if (c > 1) return 2;
        if (c > 0) return 1;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk_st("R1 state", 0);
        chk("R1 err", int'(err), 0);
        chk("R1 wake_req", int'(wake_req), 0);

        // R2 enable only
        wr(1, 0, 0, 0, 0, 0);
        tick();
        chk_st("R2 to idle", 1);
        repeat (3) tick();
        vs(0);
        chk_st("R2 stays idle", 1);

        // R3 manual entry
        wr(1, 1, 0, 0, 0, 0);
        tick();
        chk_st("R3 entering", 2);
        repeat (2) tick();
        chk_st("R3 waits vsync", 2);
        vs(0);
        chk_st("R3 held", 3);

        // R5 single-frame update
        wr(1, 1, 1, 0, 0, 0);
        chk("R5 sfu readback", int'(sfu_rb), 1);
        tick();
        chk_st("R5 one frame", 4);
        tick();
        chk_st("R5 one frame holds", 4);
        vs(0);
        chk_st("R5 back to held", 3);
        chk("R5 sfu self-clear", int'(sfu_rb), 0);

        // R4 exit
        wr(1, 0, 0, 0, 0, 0);
        tick();
        chk_st("R4 leaving", 5);
        chk("R4 wake pulse", int'(wake_req), 1);
        tick();
        chk("R4 wake single", int'(wake_req), 0);
        vs(0);
        chk_st("R4 back to idle", 1);

        // R7 disable from held
        wr(1, 1, 0, 0, 0, 0);
        tick();
        vs(0);
        chk_st("R7 held again", 3);
        wr(0, 0, 0, 0, 0, 0);
        chk("R7 entry cleared", int'(entry_rb), 0);
        tick();
        chk_st("R7 off", 0);
        chk("R7 no err", int'(err), 0);

        // R11 entry while disabled
        do_reset();
        wr(0, 1, 0, 0, 0, 0);
        chk("R11 err entry", int'(err), 1);
        chk("R11 entry dropped", int'(entry_rb), 0);
        tick();
        chk_st("R11 still off", 0);

        // R11 sfu outside held
        do_reset();
        wr(1, 0, 0, 0, 0, 0);
        tick();
        wr(1, 0, 1, 0, 0, 0);
        chk("R11 err sfu", int'(err), 1);
        chk("R11 sfu dropped", int'(sfu_rb), 0);
        tick();
        chk_st("R11 still idle", 1);

        // R11 disable during transition
        do_reset();
        wr(1, 0, 0, 0, 0, 0);
        tick();
        wr(1, 1, 0, 0, 0, 0);
        tick();
        chk_st("R11 entering", 2);
        wr(0, 0, 0, 0, 0, 0);
        chk("R11 err disable", int'(err), 1);
        chk("R11 entry kept", int'(entry_rb), 1);
        tick();
        chk_st("R11 not off", 2);
        repeat (2) tick();
        chk("R11 err sticky", int'(err), 1);

        // R8 threshold sweep
        for (int n = 0; n < 16; n++) begin
            do_reset();
            wr(1, 0, 0, 1, n, 0);
            tick();
            for (int k = 0; k < n; k++) vs(0);
            chk_st($sformatf("R8 n=%0d before", n), 1);
            vs(0);
            chk_st($sformatf("R8 n=%0d entered", n), 2);
            chk("R8 entry set", int'(entry_rb), 1);
        end

        // R9 dirty resets count
        do_reset();
        wr(1, 0, 0, 1, 3, 0);
        tick();
        repeat (3) vs(0);
        vs(1);
        chk_st("R9 dirty blocks entry", 1);
        repeat (3) vs(0);
        chk_st("R9 recount", 1);
        vs(0);
        chk_st("R9 entered", 2);

        // R10 wake code sweep
        do_reset();
        for (int c = 0; c < 16; c++) begin
            wr(0, 0, 0, 0, 0, c);
            chk($sformatf("R10 code=%0d", c), int'(wake_sel), exp_wake(c));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule